// File: doc/BRIEF.md
# SD Command Frame Transmitter

This block puts one host-to-card command frame onto a single serial command line. Software supplies a 6-bit command index and a 32-bit argument, then writes the control register with its enable bit set. The block latches both values and builds a 48-bit frame. It shifts the frame out one bit for each card-clock enable strobe, most significant bit first. A 7-bit checksum is accumulated while the first 40 bits leave the block, and it is appended right after them.

The command line is held high and undriven while the block is idle. The output enable is raised for exactly the 48 bit periods of the frame. One strobe after the closing bit, the block releases the line, clears its busy flag and gives a single-cycle done pulse. Response reception, timeouts and data-line traffic belong to other blocks.

Top module: `sd_cmd_tx`

## Requirements
- R1: After reset, cmd_out is 1, cmd_oe is 0, busy is 0 and done is 0.
- R2: A frame starts only on a clock where ctl_wr and ctl_en are both 1 and busy is 0; busy is 1 from the next clock. A write with ctl_en at 0 leaves the block idle.
- R3: A write made while busy is 1 is ignored: the frame in flight keeps the index and argument latched at its start.
- R4: Frame bit 0 is the start bit (0), bit 1 is the direction bit (1, host to card), bits 2..7 carry cmd_idx MSB first, and bits 8..39 carry cmd_arg MSB first.
- R5: Bits 40..46 carry a CRC7 with polynomial x^7+x^3+1 and initial value 0, taken over bits 0..39 and sent MSB first (command 0 with argument 0 gives the frame 0x400000000095).
- R6: Frame bit 47 is the end bit, value 1.
- R7: The k-th strobe after the start places frame bit k on cmd_out in the following clock. Without a strobe, cmd_out and cmd_oe keep their values.
- R8: cmd_oe is 1 only while the 48 frame bits are on the line, and cmd_out is 1 whenever cmd_oe is 0.
- R9: The strobe after the end bit drops cmd_oe and busy and raises done for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Card-clock enable strobe, one per bit period |
| ctl_wr | input | 1 | Control register write |
| ctl_en | input | 1 | Enable bit of the control write |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_out | output | 1 | Serial command bit |
| cmd_oe | output | 1 | Output enable of the command line |
| busy | output | 1 | A frame is pending or in flight |
| done | output | 1 | One-clock pulse after the frame ends |

## Verification
Frames are sent for every one of the 64 command indices. Each frame uses a different argument pattern and a strobe spacing of one, two or three clocks. This separates index bits from argument bits and shows whether a bit is held between strobes. Two literal frames with known checksums catch a wrong polynomial, a wrong initial value or a wrong bit order, which a checksum model shared with the design could not. A write made in the middle of a frame, and a write with the enable bit clear, show that the latched fields are protected and that a frame starts only under the stated condition.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int IDX_W     = 6;
  localparam int ARG_W     = 32;
  localparam int CRC_W     = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
  localparam int HDR_W     = 2 + IDX_W + ARG_W;
  localparam int FRAME_W   = HDR_W + CRC_W + 1;
  localparam int CNT_W     = $clog2(FRAME_W + 1);
  localparam logic START_VAL = 1'b0;
  localparam logic DIR_VAL   = 1'b1;
  localparam logic END_VAL   = 1'b1;

  typedef enum logic [1:0] {
    PH_HDR,
    PH_CRC,
    PH_END,
    PH_REL
  } phase_t;
endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7 #(
  parameter int W = 7,
  parameter logic [W-1:0] POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         upd,
  input  logic         shf,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic fb;
  assign fb = din ^ crc[W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc <= '0;
    end else if (upd) begin
      crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end else if (shf) begin
      crc <= {crc[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sd_cmd_pkg::*;
#(
  parameter int HW = HDR_W,
  parameter int CW = CRC_W,
  parameter int FW = FRAME_W,
  parameter int NW = CNT_W
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   clk_en,
  output logic   busy,
  output logic   step,
  output phase_t phase
);
  logic [NW-1:0] cnt;

  assign step = busy & clk_en;

  always_comb begin
    if (cnt < NW'(HW))           phase = PH_HDR;
    else if (cnt < NW'(HW + CW)) phase = PH_CRC;
    else if (cnt == NW'(FW - 1)) phase = PH_END;
    else                         phase = PH_REL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (step) begin
      if (cnt == NW'(FW)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int AW = ARG_W,
  parameter int CW = CRC_W,
  parameter logic [CW-1:0] POLY = CRC_POLY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en,
  input  logic          ctl_wr,
  input  logic          ctl_en,
  input  logic [IW-1:0] cmd_idx,
  input  logic [AW-1:0] cmd_arg,
  output logic          cmd_out,
  output logic          cmd_oe,
  output logic          busy,
  output logic          done
);
  localparam int HW = 2 + IW + AW;
  localparam int FW = HW + CW + 1;
  localparam int NW = $clog2(FW + 1);

  logic          start;
  logic          step;
  phase_t        phase;
  logic [HW-1:0] hdr;
  logic [CW-1:0] crc;

  assign start = ctl_wr & ctl_en & ~busy;

  sd_cmd_seq #(.HW(HW), .CW(CW), .FW(FW), .NW(NW)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .clk_en (clk_en),
    .busy   (busy),
    .step   (step),
    .phase  (phase)
  );

  sd_cmd_crc7 #(.W(CW), .POLY(POLY)) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .upd (step && phase == PH_HDR),
    .shf (step && phase == PH_CRC),
    .din (hdr[HW-1]),
    .crc (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr <= '0;
    end else if (start) begin
      hdr <= {START_VAL, DIR_VAL, cmd_idx, cmd_arg};
    end else if (step && phase == PH_HDR) begin
      hdr <= {hdr[HW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_out <= 1'b1;
      cmd_oe  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (step) begin
        unique case (phase)
          PH_HDR: begin
            cmd_out <= hdr[HW-1];
            cmd_oe  <= 1'b1;
          end
          PH_CRC: cmd_out <= crc[CW-1];
          PH_END: cmd_out <= END_VAL;
          PH_REL: begin
            cmd_out <= 1'b1;
            cmd_oe  <= 1'b0;
            done    <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sd_cmd_tx_chk.sv
module sd_cmd_tx_chk (
  input logic clk,
  input logic rst,
  input logic clk_en,
  input logic ctl_wr,
  input logic ctl_en,
  input logic cmd_out,
  input logic cmd_oe,
  input logic busy,
  input logic done
);
  AST_LINE_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cmd_oe |-> cmd_out); // R8
  AST_OE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> busy); // R8
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_en && !busy) |=> busy); // R2
  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(ctl_wr && ctl_en)) |=> !busy); // R2
  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(cmd_out) && $stable(cmd_oe))); // R7
  AST_END_BIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_oe) |-> $past(cmd_out)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !cmd_oe && $fell(cmd_oe))); // R9
endmodule

bind sd_cmd_tx sd_cmd_tx_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .clk_en (clk_en),
  .ctl_wr (ctl_wr),
  .ctl_en (ctl_en),
  .cmd_out(cmd_out),
  .cmd_oe (cmd_oe),
  .busy   (busy),
  .done   (done)
);

// File: tb/sd_cmd_tx_bench.sv
module sd_cmd_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en = 1'b0;
  logic        ctl_wr = 1'b0;
  logic        ctl_en = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_out, cmd_oe, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [47:0] got;

  always #5 clk = ~clk;

  sd_cmd_tx u_sd_cmd_tx (
    .clk(clk), .rst(rst), .clk_en(clk_en), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference frame from R4, R5, R6: header, CRC7 (x^7+x^3+1, init 0), end bit.
  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    logic [6:0]  c;
    h = {1'b0, 1'b1, idx, arg};
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb;
      fb = h[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return {h, c, 1'b1};
  endfunction

  // Send one frame; gap = clocks between strobes; poke = write mid-frame (R3).
  task automatic send(input logic [5:0] idx, input logic [31:0] arg, input int gap,
                      input bit poke);
    logic [47:0] exp;
    exp = ref_frame(idx, arg);
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; ctl_wr = 1'b1; ctl_en = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    check(busy == 1'b1 && cmd_oe == 1'b0, "R2", {busy, cmd_oe}, 2'b10);
    for (int k = 0; k <= 48; k++) begin
      for (int g = 1; g < gap; g++) begin
        if (poke && k == 10 && g == 1) begin
          cmd_idx = ~idx; cmd_arg = ~arg; ctl_wr = 1'b1;
        end
        @(negedge clk);
        ctl_wr = 1'b0;
        if (k > 0)
          check(cmd_out == exp[48-k] && cmd_oe, "R7", {cmd_oe, cmd_out}, {1'b1, exp[48-k]});
      end
      clk_en = 1'b1;
      @(negedge clk);
      clk_en = 1'b0;
      if (k < 48) begin
        got[47-k] = cmd_out;
        check(cmd_out == exp[47-k],
              k < 8 ? "R4" : (k < 40 ? "R4" : (k < 47 ? "R5" : "R6")), cmd_out, exp[47-k]);
        check(cmd_oe == 1'b1 && busy == 1'b1 && done == 1'b0, "R8", {cmd_oe, busy, done}, 3'b110);
      end else begin
        check(cmd_oe == 1'b0 && busy == 1'b0 && done == 1'b1 && cmd_out == 1'b1, "R9",
              {cmd_oe, busy, done, cmd_out}, 4'b0011);
      end
    end
    @(negedge clk);
    check(done == 1'b0 && cmd_out == 1'b1 && cmd_oe == 1'b0, "R9", {done, cmd_out, cmd_oe}, 3'b010);
    if (poke) check(got == exp, "R3", got, exp);
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 1'b0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !wd_hit) begin
        wd_hit = 1'b1;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_out == 1 && cmd_oe == 0 && busy == 0 && done == 0, "R1",
          {cmd_out, cmd_oe, busy, done}, 4'b1000);

    // R2: write with enable bit clear must not start
    ctl_wr = 1'b1; ctl_en = 1'b0; cmd_idx = 6'd5;
    @(negedge clk);
    ctl_wr = 1'b0;
    repeat (2) begin
      clk_en = 1'b1; @(negedge clk); clk_en = 1'b0;
    end
    check(busy == 0 && cmd_oe == 0 && cmd_out == 1, "R2", {busy, cmd_oe, cmd_out}, 3'b001);

    // R5: literal frames with known checksums
    send(6'd0, 32'h0, 1, 1'b0);
    check(got == 48'h400000000095, "R5", got, 48'h400000000095);
    send(6'd17, 32'h0, 2, 1'b0);
    check(got == 48'h510000000055, "R5", got, 48'h510000000055);

    // R3: write during a frame
    send(6'd42, 32'hDEADBEEF, 3, 1'b1);

    // Sweep all indices with varied arguments and strobe spacing (R4 R5 R6 R7)
    for (int i = 0; i < 64; i++) begin
      send(6'(i), 32'hA5C30F00 ^ (32'(i) * 32'h01010101) ^ {i[0] ? 32'hFFFF0000 : 32'h0},
           1 + (i % 3), 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule